// File: doc/BRIEF.md
# Sticky Event Interrupt Controller

This block gathers eight one-cycle event pulses from neighbouring timing logic and turns each into a latched flag. The sources are: a change in reference qualification, a change in cross-reference activity, a change in the selected reference for each of two timing generators, a change in PLL state for each generator, and an out-event from each generator. Once a flag is set it stays set. Software clears it by writing a one to its bit over a small register port.

A per-flag enable register decides which latched flags can raise one shared interrupt pin. A two-bit configuration register sets the asserted level of that pin. The same register decides whether the pin, while idle, is driven to the inactive level or released to high impedance. The pin is modelled as a data bit plus an output enable, so a pad cell outside the block can build the tri-state driver.

Register map (`busAddr`): 0 = flags (write-one-to-clear), 1 = enables, 2 = configuration (bit 0 `actHigh`, bit 1 `driveIdle`), 3 = unused (reads as zero).

Top module: `evt_irq_ctrl`

## Requirements
- R1: A pulse on `evtIn[i]` sets flag bit i, and only that bit, in the flag register (address 0). The new value is readable in the cycle after the pulse.
- R2: A set flag stays set for any number of cycles with no event present. Nothing but a software clear resets it.
- R3: Writing to address 0 clears every flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: If an event pulse and a clearing write hit the same flag in the same cycle, that flag ends up set.
- R5: The pin is asserted (`irqOe`=1 and `irqData` at the asserted level) exactly when at least one flag is set while its enable bit (address 1, bit i) is 1.
- R6: Configuration bit 0 selects the asserted level: 1 gives high, 0 gives low. The idle level is the opposite of the asserted level.
- R7: Configuration bit 1 selects the idle behaviour: 1 drives the inactive level with `irqOe`=1, and 0 gives `irqOe`=0. While the pin is asserted, `irqOe` is always 1.
- R8: After reset, flags, enables and both configuration bits are 0. The pin is therefore idle with `irqOe`=0.
- R9: Writes to address 1 or 2 read back unchanged. Their effect on the pin appears in the cycle after the write.
- R10: A write to address 3 changes no register and leaves the pin unchanged. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtIn | input | NUM_EVT | One-cycle event pulses, one per flag |
| busAddr | input | ADDR_W | Register address |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | NUM_EVT | Write data |
| busRdData | output | NUM_EVT | Read data of the addressed register (combinational) |
| irqData | output | 1 | Interrupt pin data level |
| irqOe | output | 1 | Interrupt pin output enable |

## Verification
The assertions assume that event pulses and bus writes are synchronous to `clk`. They also assume the write strobe is qualified by a stable address and data for the whole cycle in which it is high. The directed stimulus changes every input only on the falling edge and holds the strobe for exactly one cycle. It raises events only outside reset, including the cycle in which a clearing write hits the same flag. Every configuration value and an unused-address write are driven through the same port, so no assertion depends on an input pattern the bench cannot produce.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int ADDR_FLAGS = 0;
  localparam int ADDR_ENABLE = 1;
  localparam int ADDR_CONFIG = 2;
  localparam int CFG_W = 2;

  typedef enum logic [1:0] {
    SEL_FLAGS  = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_CONFIG = 2'd2,
    SEL_NONE   = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   clrFlags;
    logic   wrEnable;
    logic   wrConfig;
    rdSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/evt_irq_ctl.sv
module evt_irq_ctl
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctlStrobe_t        strobe
);

  logic hitFlags;
  logic hitEnable;
  logic hitConfig;

  // Address decode: one hit line per implemented register
  assign hitFlags  = (busAddr == ADDR_W'(ADDR_FLAGS));
  assign hitEnable = (busAddr == ADDR_W'(ADDR_ENABLE));
  assign hitConfig = (busAddr == ADDR_W'(ADDR_CONFIG));

  always_comb begin
    strobe          = '0;
    strobe.clrFlags = busWrEn & hitFlags;
    strobe.wrEnable = busWrEn & hitEnable;
    strobe.wrConfig = busWrEn & hitConfig;
    if (hitFlags)       strobe.rdSel = SEL_FLAGS;
    else if (hitEnable) strobe.rdSel = SEL_ENABLE;
    else if (hitConfig) strobe.rdSel = SEL_CONFIG;
    else                strobe.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/evt_irq_dp.sv
module evt_irq_dp
  import evt_irq_pkg::*;
#(
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  input  ctlStrobe_t         strobe,
  input  logic [NUM_EVT-1:0] wrData,
  output logic [NUM_EVT-1:0] flagsQ,
  output logic [NUM_EVT-1:0] enableQ,
  output logic               actHighQ,
  output logic               driveIdleQ,
  output logic [NUM_EVT-1:0] rdData,
  output logic               irqData,
  output logic               irqOe
);

  logic anyHit;

  // One sticky cell per event; a new event wins over a clear
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    logic bitQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                           bitQ <= 1'b0;
      else if (evtIn[i])                   bitQ <= 1'b1;
      else if (strobe.clrFlags && wrData[i]) bitQ <= 1'b0;
    end
    assign flagsQ[i] = bitQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
    end else if (strobe.wrEnable) begin
      enableQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actHighQ   <= 1'b0;
      driveIdleQ <= 1'b0;
    end else if (strobe.wrConfig) begin
      actHighQ   <= wrData[0];
      driveIdleQ <= wrData[1];
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_FLAGS:  rdData = flagsQ;
      SEL_ENABLE: rdData = enableQ;
      SEL_CONFIG: rdData = NUM_EVT'({driveIdleQ, actHighQ});
      default:    rdData = '0;
    endcase
  end

  // Pin stage
  assign anyHit  = |(flagsQ & enableQ);
  assign irqOe   = anyHit | driveIdleQ;
  assign irqData = anyHit ? actHighQ : ~actHighQ;

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [NUM_EVT-1:0] busWrData,
  output logic [NUM_EVT-1:0] busRdData,
  output logic               irqData,
  output logic               irqOe
);

  ctlStrobe_t         strobe;
  logic [NUM_EVT-1:0] flagsQ;
  logic [NUM_EVT-1:0] enableQ;
  logic               actHighQ;
  logic               driveIdleQ;

  evt_irq_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  evt_irq_dp #(.NUM_EVT(NUM_EVT)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .evtIn      (evtIn),
    .strobe     (strobe),
    .wrData     (busWrData),
    .flagsQ     (flagsQ),
    .enableQ    (enableQ),
    .actHighQ   (actHighQ),
    .driveIdleQ (driveIdleQ),
    .rdData     (busRdData),
    .irqData    (irqData),
    .irqOe      (irqOe)
  );

endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
  import evt_irq_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int ADDR_W  = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_EVT-1:0] evtIn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWrEn,
  input logic [NUM_EVT-1:0] busWrData,
  input logic [NUM_EVT-1:0] flagsQ,
  input logic [NUM_EVT-1:0] enableQ,
  input logic               actHighQ,
  input logic               driveIdleQ,
  input logic               irqData,
  input logic               irqOe
);

  logic [NUM_EVT-1:0] clrReq;
  logic               wrEnableReq;
  logic               hot;

  assign clrReq      = (busWrEn && busAddr == ADDR_W'(ADDR_FLAGS)) ? busWrData : '0;
  assign wrEnableReq = busWrEn && busAddr == ADDR_W'(ADDR_ENABLE);
  assign hot         = |(flagsQ & enableQ);

  AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((flagsQ & $past(evtIn)) == $past(evtIn))); // R4

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagsQ & ~$past(flagsQ) & ~$past(evtIn)) == '0)); // R1

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(flagsQ) & ~$past(clrReq) & ~flagsQ) == '0)); // R2

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq != '0) |=> ((flagsQ & $past(clrReq) & ~$past(evtIn)) == '0)); // R3

  AST_PIN_ASSERTED: assert property (@(posedge clk) disable iff (!rstN)
    hot |-> (irqOe && irqData == actHighQ)); // R5

  AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !hot |-> (irqOe == driveIdleQ && (!irqOe || irqData == !actHighQ))); // R7

  AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrEnableReq |=> (enableQ == $past(busWrData))); // R9

endmodule

bind evt_irq_ctrl evt_irq_chk #(.NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .evtIn      (evtIn),
  .busAddr    (busAddr),
  .busWrEn    (busWrEn),
  .busWrData  (busWrData),
  .flagsQ     (flagsQ),
  .enableQ    (enableQ),
  .actHighQ   (actHighQ),
  .driveIdleQ (driveIdleQ),
  .irqData    (irqData),
  .irqOe      (irqOe)
);

// File: tb/evt_irq_ctrl_bench.sv
`timescale 1ns/1ps
module evt_irq_ctrl_bench;

  localparam int NUM_EVT = 8;
  localparam int ADDR_W  = 2;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_EVT-1:0] evtIn = '0;
  logic [ADDR_W-1:0]  busAddr = '0;
  logic               busWrEn = 1'b0;
  logic [NUM_EVT-1:0] busWrData = '0;
  logic [NUM_EVT-1:0] busRdData;
  logic               irqData;
  logic               irqOe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  evt_irq_ctrl #(.NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W)) u_evt_irq_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evtIn     (evtIn),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .irqData   (irqData),
    .irqOe     (irqOe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input int addr, input int data);
    busAddr   = ADDR_W'(addr);
    busWrData = NUM_EVT'(data);
    busWrEn   = 1'b1;
    @(negedge clk);
    busWrEn   = 1'b0;
    busWrData = '0;
  endtask

  task automatic busRead(input int addr, output int data);
    busAddr = ADDR_W'(addr);
    #0.5;
    data = int'(busRdData);
  endtask

  task automatic pulse(input int mask);
    evtIn = NUM_EVT'(mask);
    @(negedge clk);
    evtIn = '0;
  endtask

  task automatic checkPin(input string req, input int expOe, input int expData);
    check({req, " oe"}, int'(irqOe), expOe);
    if (expOe == 1) check({req, " data"}, int'(irqData), expData);
  endtask

  task automatic t_reset();
    int v;
    busRead(0, v); check("R8 flags", v, 0);
    busRead(1, v); check("R8 enable", v, 0);
    busRead(2, v); check("R8 config", v, 0);
    checkPin("R8 pin", 0, 0);
  endtask

  task automatic t_latch();
    int v;
    for (int i = 0; i < NUM_EVT; i++) begin
      pulse(1 << i);
      busRead(0, v); check("R1 single bit set", v, 1 << i);
      busWrite(0, 1 << i);
      busRead(0, v); check("R3 clear", v, 0);
    end
  endtask

  task automatic t_sticky();
    int v;
    pulse(8'h05);
    repeat (6) @(negedge clk);
    busRead(0, v); check("R2 sticky", v, 8'h05);
    busWrite(0, 8'h01);
    busRead(0, v); check("R3 partial clear", v, 8'h04);
    busWrite(0, 8'h00);
    busRead(0, v); check("R3 zero write", v, 8'h04);
    busWrite(0, 8'hFF);
    busRead(0, v); check("R3 full clear", v, 0);
  endtask

  task automatic t_collision();
    int v;
    pulse(8'h0A);
    evtIn = 8'h08;
    busWrite(0, 8'h0A);
    evtIn = '0;
    busRead(0, v); check("R4 event beats clear", v, 8'h08);
    busWrite(0, 8'h08);
    busRead(0, v); check("R4 later clear", v, 0);
  endtask

  task automatic t_pin();
    int v;
    pulse(8'h40);
    checkPin("R5 masked idle", 0, 0);
    busWrite(1, 8'h40);
    checkPin("R9 R5 enable active low", 1, 0);
    busRead(1, v); check("R9 enable readback", v, 8'h40);
    busWrite(1, 8'hBF);
    checkPin("R5 other bits enabled", 0, 0);
    busWrite(1, 8'hFF);
    checkPin("R5 reenabled", 1, 0);
    busWrite(0, 8'h40);
    checkPin("R5 after clear", 0, 0);
  endtask

  task automatic t_polarity();
    int v;
    busWrite(2, 1);
    busRead(2, v); check("R9 config readback", v, 1);
    checkPin("R7 tri idle", 0, 0);
    pulse(8'h80);
    checkPin("R6 active high", 1, 1);
    busWrite(2, 0);
    checkPin("R9 R6 polarity next cycle", 1, 0);
    busWrite(0, 8'h80);
    busWrite(2, 3);
    checkPin("R7 driven idle high-pol", 1, 0);
    busWrite(2, 2);
    checkPin("R7 driven idle low-pol", 1, 1);
    pulse(8'h02);
    checkPin("R7 asserted low", 1, 0);
    busWrite(0, 8'h02);
    busWrite(2, 0);
    checkPin("R7 back to tri", 0, 0);
  endtask

  task automatic t_unused();
    int v;
    pulse(8'h10);
    busWrite(1, 8'h00);
    busWrite(3, 8'hFF);
    busRead(0, v); check("R10 flags kept", v, 8'h10);
    busRead(1, v); check("R10 enable kept", v, 0);
    busRead(2, v); check("R10 config kept", v, 0);
    busRead(3, v); check("R10 read zero", v, 0);
    checkPin("R10 pin unchanged", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_sticky();
    t_collision();
    t_pin();
    t_polarity();
    t_unused();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule